// File: doc/BRIEF.md
# Delay-Line Multiply-Accumulate Engine

This block is a small DSP execution unit. It takes one 16-bit instruction word at a time through a valid/ready handshake. Each word reads one operand from an X data memory and one from a Y data memory, each 64 words deep. The block multiplies the two operands as signed values. It then adds the product to a wide accumulator, or loads the product into it.

Alongside the arithmetic, every executed word moves a two-stage Y pipeline forward. The front stage can take the Y operand just read. The rear stage can be written back into Y memory at the same address, at the cost of one extra cycle. With this, a filter loop can shift its sample history through Y memory in place, using no separate move instructions.

A host loads both memories through a write port and reads them back through a read port. It reads the accumulator on a dedicated output.

Top module: `dlmac_top`

## Requirements
- R1: After a synchronous reset, `accOut` is 0, `instReady` is 1, `busy` is 0, and both pipeline stages hold 0.
- R2: A word is executed only if bit 15 is 1. With bit 14 = 0, the accumulator becomes its old value plus X[bits 11:6] × Y[bits 5:0]. The new value shows on `accOut` one cycle after acceptance, and `accOut` holds while no word is accepted.
- R3: With bit 14 = 1, the accumulator becomes the product alone, and the old value is discarded.
- R4: Operands are 16-bit two's complement and the product is 32 bits signed. The product is sign-extended into a 40-bit accumulator that wraps on overflow.
- R5: With bit 12 = 1, the front pipeline stage takes Y[bits 5:0] as it was before the word. With bit 12 = 0, the front stage keeps its value.
- R6: Every executed word copies the old front stage into the rear stage.
- R7: With bit 13 = 1, the updated rear stage is written to Y[bits 5:0], and the word takes two cycles. In the second cycle `busy` is 1 and `instReady` is 0. A word with bit 13 = 0 takes one cycle and never raises `busy`.
- R8: A word with bit 15 = 0 is accepted in one cycle and changes nothing: not the accumulator, not the pipeline, not memory, and `busy` stays low.
- R9: Host writes (`hostXWe`, `hostYWe`) have no effect while `busy` is 1.
- R10: `hostXRData` and `hostYRData` show X and Y memory at `hostRdAddr` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Instruction word offered |
| instReady | output | 1 | Engine can accept a word this cycle |
| instWord | input | 16 | Instruction word |
| busy | output | 1 | Second cycle of a write-back word |
| hostXWe | input | 1 | Host write strobe, X memory |
| hostYWe | input | 1 | Host write strobe, Y memory |
| hostWrAddr | input | 6 | Host write address |
| hostWData | input | 16 | Host write data |
| hostRdAddr | input | 6 | Host read address |
| hostXRData | output | 16 | X memory word at `hostRdAddr` |
| hostYRData | output | 16 | Y memory word at `hostRdAddr` |
| accOut | output | 40 | Accumulator |

## Verification
The bench follows a three-word chain through the delay line and reads back what lands in Y memory. A design that loaded the new Y word into the rear stage, or that wrote back the stale rear stage, leaves the wrong sample at the target address. The chain also checks that a word without the load flag leaves the front stage alone. A host write is attempted during the busy cycle, which would corrupt memory if the block did not block it. The bench drives 512 accumulations of 2^30 to reach the 40-bit wrap, and multiplies a negative operand by a positive one. A design that zero-extends the operands or the product fails both.

// File: rtl/dlmac_pkg.sv
package dlmac_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int ACC_W  = 40;
  localparam int PROD_W = 2 * DATA_W;

  // instruction field positions
  localparam int B_EXEC = 15;
  localparam int B_CLR  = 14;
  localparam int B_STORE = 13;
  localparam int B_LOAD = 12;

  typedef struct packed {
    logic accEn;
    logic accClr;
    logic shiftEn;
    logic loadLy;
    logic capAddr;
    logic storeY;
  } strobe_t;
endpackage

// File: rtl/dlmac_ctrl.sv
module dlmac_ctrl
  import dlmac_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instValid,
  input  logic [15:0] instWord,
  output logic        instReady,
  output logic        busy,
  output strobe_t     strb
);
  typedef enum logic {S_IDLE, S_STORE} state_t;
  state_t state, stateNext;

  logic isMac;
  assign isMac = instValid && (state == S_IDLE) && instWord[B_EXEC];

  always_comb begin
    strb = '0;
    stateNext = state;
    if (state == S_IDLE) begin
      strb.accEn   = isMac;
      strb.accClr  = instWord[B_CLR];
      strb.shiftEn = isMac;
      strb.loadLy  = isMac && instWord[B_LOAD];
      strb.capAddr = isMac;
      if (isMac && instWord[B_STORE]) stateNext = S_STORE;
    end else begin
      strb.storeY = 1'b1;
      stateNext   = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

  assign busy      = (state == S_STORE);
  assign instReady = (state == S_IDLE);
endmodule

// File: rtl/dlmac_dpath.sv
module dlmac_dpath
  import dlmac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int AC = ACC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       strb,
  input  logic          busy,
  input  logic [AW-1:0] xAddr,
  input  logic [AW-1:0] yAddr,
  input  logic          hostXWe,
  input  logic          hostYWe,
  input  logic [AW-1:0] hostWrAddr,
  input  logic [DW-1:0] hostWData,
  input  logic [AW-1:0] hostRdAddr,
  output logic [DW-1:0] hostXRData,
  output logic [DW-1:0] hostYRData,
  output logic [AC-1:0] accOut
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = 2 * DW;

  logic [DW-1:0] xMem [DEPTH];
  logic [DW-1:0] yMem [DEPTH];
  logic [DW-1:0] dspLy, lyDly;
  logic [AW-1:0] yAddrQ;
  logic [AC-1:0] acc;

  logic signed [DW-1:0] xOp, yOp;
  logic signed [PW-1:0] prod;
  logic signed [AC-1:0] prodExt, accBase;

  assign xOp     = $signed(xMem[xAddr]);
  assign yOp     = $signed(yMem[yAddr]);
  assign prod    = xOp * yOp;
  assign prodExt = AC'(prod);
  assign accBase = strb.accClr ? '0 : $signed(acc);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      dspLy <= '0;
      lyDly <= '0;
    end else begin
      if (strb.accEn)   acc   <= accBase + prodExt;
      if (strb.shiftEn) lyDly <= dspLy;
      if (strb.loadLy)  dspLy <= yOp;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.capAddr) yAddrQ <= yAddr;
  end

  always_ff @(posedge clk) begin
    if (hostXWe && !busy) xMem[hostWrAddr] <= hostWData;
  end

  always_ff @(posedge clk) begin
    if (strb.storeY)            yMem[yAddrQ]     <= lyDly;
    else if (hostYWe && !busy)  yMem[hostWrAddr] <= hostWData;
  end

  assign hostXRData = xMem[hostRdAddr];
  assign hostYRData = yMem[hostRdAddr];
  assign accOut     = acc;
endmodule

// File: rtl/dlmac_top.sv
module dlmac_top
  import dlmac_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instValid,
  output logic        instReady,
  input  logic [15:0] instWord,
  output logic        busy,
  input  logic        hostXWe,
  input  logic        hostYWe,
  input  logic [5:0]  hostWrAddr,
  input  logic [15:0] hostWData,
  input  logic [5:0]  hostRdAddr,
  output logic [15:0] hostXRData,
  output logic [15:0] hostYRData,
  output logic [39:0] accOut
);
  strobe_t strb;

  dlmac_ctrl u_ctrl (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .instReady(instReady), .busy(busy), .strb(strb)
  );

  dlmac_dpath #(.DW(DATA_W), .AW(ADDR_W), .AC(ACC_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .busy(busy),
    .xAddr(instWord[11:6]), .yAddr(instWord[5:0]),
    .hostXWe(hostXWe), .hostYWe(hostYWe), .hostWrAddr(hostWrAddr),
    .hostWData(hostWData), .hostRdAddr(hostRdAddr),
    .hostXRData(hostXRData), .hostYRData(hostYRData), .accOut(accOut)
  );
endmodule

// File: rtl/dlmac_chk.sv
module dlmac_chk (
  input logic        clk,
  input logic        rst,
  input logic        instValid,
  input logic        instReady,
  input logic [15:0] instWord,
  input logic        busy,
  input logic [39:0] accOut
);
  logic accept;
  assign accept = instValid && instReady;

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (accOut == '0) && !busy && instReady);

  // R2
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst) !accept |=> $stable(accOut));

  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst) busy |-> !instReady);

  // R7
  store_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && instWord[15] && instWord[13]) |=> busy);

  // R7
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst) busy |=> !busy);

  // R8
  nonmac_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !instWord[15]) |=> ($stable(accOut) && !busy));
endmodule

bind dlmac_top dlmac_chk u_chk (
  .clk(clk), .rst(rst), .instValid(instValid), .instReady(instReady),
  .instWord(instWord), .busy(busy), .accOut(accOut)
);

// File: tb/sim_dlmac_top.sv
`timescale 1ns/1ps
module sim_dlmac_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        instValid = 0;
  logic        instReady;
  logic [15:0] instWord = '0;
  logic        busy;
  logic        hostXWe = 0, hostYWe = 0;
  logic [5:0]  hostWrAddr = '0, hostRdAddr = '0;
  logic [15:0] hostWData = '0;
  logic [15:0] hostXRData, hostYRData;
  logic [39:0] accOut;

  int nRun = 0, nFail = 0;

  always #2.5 clk = ~clk;

  dlmac_top u0 (.*);

  localparam int NV = 6;
  // word: {exec, clr, store, load, xaddr, yaddr}; X[a]=a+1, Y[a]=a-32
  localparam logic [15:0] VEC_WORD [NV] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 6'd2,  6'd40},
    {1'b1, 1'b0, 1'b0, 1'b0, 6'd5,  6'd10},
    {1'b1, 1'b0, 1'b0, 1'b0, 6'd0,  6'd0},
    {1'b1, 1'b1, 1'b0, 1'b0, 6'd63, 6'd63},
    16'h7FFF,
    {1'b1, 1'b0, 1'b0, 1'b0, 6'd9,  6'd32}
  };
  localparam logic signed [39:0] VEC_ACC [NV] = '{
    40'sd24, -40'sd108, -40'sd140, 40'sd1984, 40'sd1984, 40'sd1984
  };
  localparam string VEC_REQ [NV] = '{"R3", "R2", "R4", "R3", "R8", "R2"};

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit clr, input bit st, input bit ld, input int xa, input int ya);
    return {1'b1, clr, st, ld, 6'(xa), 6'(ya)};
  endfunction

  // issues one word; returns at the negedge where the result is visible
  task automatic issue(input logic [15:0] w, input bit expectStore);
    @(negedge clk);
    instValid = 1; instWord = w;
    @(negedge clk);
    instValid = 0;
    if (expectStore) begin
      check(busy && !instReady, "R7", {busy, instReady}, 2'b10);
      @(negedge clk);
    end
    check(!busy && instReady, "R7", {busy, instReady}, 2'b01);
  endtask

  task automatic hostWrite(input bit toY, input int a, input logic [15:0] d);
    @(negedge clk);
    hostXWe = !toY; hostYWe = toY; hostWrAddr = 6'(a); hostWData = d;
    @(negedge clk);
    hostXWe = 0; hostYWe = 0;
  endtask

  task automatic readY(input int a, output logic [15:0] d);
    hostRdAddr = 6'(a); #0.1; d = hostYRData;
  endtask

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check(accOut == '0, "R1", accOut, 0);
    check(instReady && !busy, "R1", {instReady, busy}, 2'b10);

    for (int a = 0; a < 64; a++) hostWrite(0, a, 16'(a + 1));
    for (int a = 0; a < 64; a++) hostWrite(1, a, 16'(a - 32));
    hostRdAddr = 6'd7; #0.1;
    check(hostXRData == 16'd8, "R10", hostXRData, 8);
    check(hostYRData == 16'hFFE7, "R10", hostYRData, 16'hFFE7);

    for (int i = 0; i < NV; i++) begin
      issue(VEC_WORD[i], 1'b0);
      check($signed(accOut) == VEC_ACC[i], VEC_REQ[i], accOut, VEC_ACC[i]);
    end

    // R8: non-executed word with store bit left memory alone
    readY(63, rd);
    check(rd == 16'd31, "R8", rd, 31);

    // Delay line chain R5 R6 R7
    issue(mk(1, 0, 1, 0, 1), 1'b0);          // front=-31, rear=0
    issue(mk(1, 1, 1, 0, 2), 1'b1);          // rear=-31, front=-30, Y[2]=-31
    readY(2, rd);
    check(rd == 16'hFFE1, "R6", rd, 16'hFFE1);
    issue(mk(1, 1, 0, 0, 3), 1'b1);          // rear=-30, front kept, Y[3]=-30
    readY(3, rd);
    check(rd == 16'hFFE2, "R5", rd, 16'hFFE2);

    // R9: host write during busy cycle of a store word
    @(negedge clk);
    instValid = 1; instWord = mk(1, 1, 0, 0, 4);
    @(negedge clk);
    instValid = 0;
    hostXWe = 1; hostWrAddr = 6'd7; hostWData = 16'd999;
    check(busy, "R9", busy, 1);
    @(negedge clk);
    hostXWe = 0;
    hostRdAddr = 6'd7; #0.1;
    check(hostXRData == 16'd8, "R9", hostXRData, 8);
    readY(4, rd);
    check(rd == 16'hFFE2, "R5", rd, 16'hFFE2);  // front unchanged by LDLY=0

    // R4: signed product and 40-bit wrap
    hostWrite(0, 62, 16'h8000);
    hostWrite(1, 61, 16'h8000);
    hostWrite(1, 60, 16'h7FFF);
    issue(mk(1, 0, 0, 62, 60), 1'b0);
    check($signed(accOut) == -40'sd1073709056, "R4", accOut, -40'sd1073709056);
    issue(mk(1, 0, 0, 62, 61), 1'b0);
    check($signed(accOut) == 40'sd1073741824, "R3", accOut, 40'sd1073741824);
    for (int k = 1; k < 512; k++) issue(mk(0, 0, 0, 62, 61), 1'b0);
    check(accOut == 40'h80_0000_0000, "R4", accOut, 40'h80_0000_0000);

    // R2: idle cycles leave accumulator alone
    repeat (3) @(negedge clk);
    check(accOut == 40'h80_0000_0000, "R2", accOut, 40'h80_0000_0000);

    // R1: reset again
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    check(accOut == '0 && instReady && !busy, "R1", accOut, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule